// File: doc/BRIEF.md
# Timer Compare Match Channel

This block is a single compare channel attached to a free-running timebase that lives elsewhere on the chip. Software loads a compare value one byte at a time over a small byte-wide register bus and sets the channel's mode bits. When the channel is armed and the timebase reaches the compare value, the block sets a sticky match flag. It also asserts an interrupt request while that flag is set, provided interrupts are enabled.

Writes to the compare bytes disarm and rearm the channel. A write to the lowest byte clears the compare-enable bit and a write to the highest byte sets it again. Because software loads the low byte first and the high byte last, the comparator is never armed while the value is only half written. The flag is never cleared by hardware. Only a software write clears it. If a clear and a new match arrive in the same cycle, the match is kept.

Register map, with addresses in bus words: 0 is the mode register, 1 is the flag register, and 2 upward hold the compare bytes, lowest byte first. Addresses that are not in the map read as zero and ignore writes.

Top module: `cmp_channel`

## Requirements
- R1: After a synchronous reset the mode register, both compare bytes and the flag read 0, and `irq_o` and `flag_o` are 0.
- R2: Address 2 holds compare bits 7:0 and address 3 holds bits 15:8, and both read back what was written. The mode register at address 0 has bit 0 = compare enable, bit 1 = match enable and bit 2 = interrupt enable. Its other bits read 0.
- R3: A write to the compare low byte (address 2) forces mode bit 0 to 0 and leaves mode bits 1 and 2 unchanged.
- R4: A write to the compare high byte (address 3) forces mode bit 0 to 1.
- R5: If mode bits 0 and 1 are both 1 and `tbase_i` equals the compare value at a rising clock edge, `flag_o` (also flag register bit 0 at address 1) is 1 from that edge on.
- R6: While mode bit 0 or mode bit 1 is 0, equality between `tbase_i` and the compare value leaves the flag at 0.
- R7: The flag stays 1 after `tbase_i` moves on. A bus write to address 1 with data bit 0 = 0 clears it. A write there with data bit 0 = 1 leaves it unchanged.
- R8: `irq_o` equals the flag ANDed with mode bit 2, at all times.
- R9: If a flag-clear write and a match happen at the same edge, the flag ends up 1.
- R10: After a low-byte write and before the high-byte write, a timebase equal to the half-updated value, or to the old value, does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | TB_W (16) | Current value of the shared timebase |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W (2) | Bus word address |
| wdata_i | input | BYTE_W (8) | Bus write data |
| rdata_o | output | BYTE_W (8) | Combinational read data for `addr_i` |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
The comparator is tested with timebase values just below, at and just above the compare value. This separates a true equality detect from an off-by-one. Each arming combination is tried: compare enable alone, match enable alone, and both. This shows that both bits gate the match. During a two-byte reload the timebase is driven to the half-updated value and to the old value, which shows that the low-byte write disarms the channel. Clear writes are issued with data bit 0 at 1, with it at 0, and in the same cycle as a match, which separates a real clear from a write that is ignored and shows that the match has priority.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

    // Mode register layout: bit 2 interrupt enable, bit 1 match enable, bit 0 compare enable.
    typedef struct packed {
        logic irq_en;
        logic match_en;
        logic cmp_en;
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    // Fixed word addresses on the register bus.
    localparam int unsigned ADDR_MODE = 0;
    localparam int unsigned ADDR_FLAG = 1;
    localparam int unsigned ADDR_CMP0 = 2;

    // Effect of a bus write on the compare-enable bit.
    typedef enum logic [1:0] {
        CE_KEEP  = 2'd0,
        CE_CLEAR = 2'd1,
        CE_SET   = 2'd2
    } ce_op_e;

    // The top byte lane rearms the channel. The bottom lane disarms it.
    // With a single lane, the top-lane rule wins.
    function automatic ce_op_e lane_ce_op(input int unsigned lane, input int unsigned nlanes);
        if (lane == nlanes - 1) return CE_SET;
        if (lane == 0)          return CE_CLEAR;
        return CE_KEEP;
    endfunction

    function automatic logic armed(input mode_t m);
        return m.cmp_en && m.match_en;
    endfunction

endpackage

// File: rtl/cmpch_regs.sv
module cmpch_regs
    import cmpch_pkg::*;
#(
    parameter int unsigned TB_W   = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag,
    output logic [TB_W-1:0]   cmp_val,
    output mode_t             mode,
    output logic              clr_req,
    output logic [BYTE_W-1:0] rdata
);
    localparam int unsigned NLANES = TB_W / BYTE_W;

    logic [NLANES-1:0] lane_wr;
    ce_op_e            lane_op [NLANES];
    ce_op_e            ce_op;
    logic              mode_wr;

    assign mode_wr = wr_en && (addr == ADDR_W'(ADDR_MODE));
    assign clr_req = wr_en && (addr == ADDR_W'(ADDR_FLAG)) && !wdata[0];

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic [BYTE_W-1:0] byte_q;
        assign lane_wr[i] = wr_en && (addr == ADDR_W'(ADDR_CMP0 + i));
        assign lane_op[i] = lane_wr[i] ? lane_ce_op(i, NLANES) : CE_KEEP;
        always_ff @(posedge clk) begin
            if (rst)             byte_q <= '0;
            else if (lane_wr[i]) byte_q <= wdata;
        end
        assign cmp_val[i*BYTE_W +: BYTE_W] = byte_q;
    end

    // Only one address is written per cycle, so at most one lane op is active.
    always_comb begin
        ce_op = CE_KEEP;
        for (int i = 0; i < NLANES; i++) begin
            if (lane_op[i] != CE_KEEP) ce_op = lane_op[i];
        end
    end

    mode_t mode_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_t'(wdata[MODE_W-1:0]);
        end else begin
            case (ce_op)
                CE_SET:   mode_q.cmp_en <= 1'b1;
                CE_CLEAR: mode_q.cmp_en <= 1'b0;
                default:  ;
            endcase
        end
    end
    assign mode = mode_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_MODE)) rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
        if (addr == ADDR_W'(ADDR_FLAG)) rdata = {{(BYTE_W-1){1'b0}}, flag};
        for (int i = 0; i < NLANES; i++) begin
            if (addr == ADDR_W'(ADDR_CMP0 + i)) rdata = cmp_val[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/cmpch_match.sv
module cmpch_match
    import cmpch_pkg::*;
#(
    parameter int unsigned TB_W   = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [TB_W-1:0] tbase,
    input  logic [TB_W-1:0] cmp_val,
    input  mode_t           mode,
    output logic            hit
);
    localparam int unsigned NLANES = TB_W / BYTE_W;

    logic [NLANES-1:0] lane_eq;

    for (genvar i = 0; i < NLANES; i++) begin : g_eq
        assign lane_eq[i] = (tbase[i*BYTE_W +: BYTE_W] == cmp_val[i*BYTE_W +: BYTE_W]);
    end

    assign hit = armed(mode) && (&lane_eq);

endmodule

// File: rtl/cmpch_flag.sv
module cmpch_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // A match takes priority over a clear issued in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q && irq_en;

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmpch_pkg::*;
#(
    parameter int unsigned TB_W   = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = $clog2(TB_W / BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TB_W-1:0]   tbase_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              flag_o,
    output logic              irq_o
);
    mode_t           mode_w;
    logic [TB_W-1:0] cmp_val_w;
    logic            clr_w;
    logic            hit_w;
    logic            flag_w;

    cmpch_regs #(.TB_W(TB_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .flag    (flag_w),
        .cmp_val (cmp_val_w),
        .mode    (mode_w),
        .clr_req (clr_w),
        .rdata   (rdata_o)
    );

    cmpch_match #(.TB_W(TB_W), .BYTE_W(BYTE_W)) i_match (
        .tbase   (tbase_i),
        .cmp_val (cmp_val_w),
        .mode    (mode_w),
        .hit     (hit_w)
    );

    cmpch_flag i_flag (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit_w),
        .clr_req (clr_w),
        .irq_en  (mode_w.irq_en),
        .flag    (flag_w),
        .irq     (irq_o)
    );

    assign flag_o = flag_w;

endmodule

// File: rtl/cmp_channel_chk.sv
module cmp_channel_chk #(
    parameter int unsigned TB_W   = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [TB_W-1:0]   tbase_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BYTE_W-1:0] wdata_i,
    input logic              flag_o,
    input logic              irq_o,
    input logic [2:0]        mode_bits,
    input logic [TB_W-1:0]   cmp_val
);
    localparam int unsigned NLANES = TB_W / BYTE_W;
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2 + NLANES - 1);

    logic eq_armed;
    assign eq_armed = mode_bits[0] && mode_bits[1] && (tbase_i == cmp_val);

    p_cmp_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(cmp_val));

    p_low_write_disarms_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == A_LO) |=> !mode_bits[0]);

    p_high_write_arms_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == A_HI) |=> mode_bits[0]);

    // Covers R9 too: a same-cycle clear must not defeat the match.
    p_match_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        eq_armed |=> flag_o);

    p_rise_needs_match_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(eq_armed));

    p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag_o) && !$past(rst)) |-> $past(wr_en_i && addr_i == A_FLAG && !wdata_i[0]));

    p_irq_tracks_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (flag_o && mode_bits[2]));

endmodule

bind cmp_channel cmp_channel_chk #(.TB_W(TB_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tbase_i   (tbase_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .mode_bits (mode_w),
    .cmp_val   (cmp_val_w)
);

// File: tb/test_cmp_channel.sv
`timescale 1ns/1ps
module test_cmp_channel;
    localparam logic [15:0] IDLE = 16'hAAAA;
    localparam logic [1:0] A_MODE = 2'd0, A_FLAG = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tbase = IDLE;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        flag, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_channel i_cmp_channel (
        .clk(clk), .rst(rst), .tbase_i(tbase), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .flag_o(flag), .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Drive the timebase to v for one edge, then return it to idle.
    task automatic pulse_tb(input logic [15:0] v);
        @(negedge clk);
        tbase = v;
        @(negedge clk);
        tbase = IDLE;
    endtask

    task automatic clear_flag();
        bus_wr(A_FLAG, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 flag_o", 16'(flag), 16'h0);
        check("R1 irq_o", 16'(irq), 16'h0);
        bus_rd(A_MODE, d); check("R1 mode", 16'(d), 16'h0);
        bus_rd(A_FLAG, d); check("R1 flag reg", 16'(d), 16'h0);
        bus_rd(A_LO, d);   check("R1 cmp lo", 16'(d), 16'h0);
        bus_rd(A_HI, d);   check("R1 cmp hi", 16'(d), 16'h0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_wr(A_MODE, 8'hFF);
        bus_rd(A_MODE, d); check("R2 mode upper bits read 0", 16'(d), 16'h07);
        bus_wr(A_LO, 8'h34);
        bus_rd(A_MODE, d); check("R3 low write clears bit0 only", 16'(d), 16'h06);
        bus_wr(A_HI, 8'h12);
        bus_rd(A_MODE, d); check("R4 high write sets bit0", 16'(d), 16'h07);
        bus_rd(A_LO, d);   check("R2 cmp lo readback", 16'(d), 16'h34);
        bus_rd(A_HI, d);   check("R2 cmp hi readback", 16'(d), 16'h12);
        bus_wr(A_MODE, 8'h00);
    endtask

    task automatic t_match();
        logic [7:0] d;
        bus_wr(A_MODE, 8'h02);          // match enable only
        bus_wr(A_LO, 8'h34);
        bus_wr(A_HI, 8'h12);            // now armed, value 0x1234
        pulse_tb(16'h1233);
        check("R5 below value no flag", 16'(flag), 16'h0);
        pulse_tb(16'h1235);
        check("R5 above value no flag", 16'(flag), 16'h0);
        pulse_tb(16'h1234);
        check("R5 equality sets flag", 16'(flag), 16'h1);
        pulse_tb(16'h1236);
        check("R7 flag sticky", 16'(flag), 16'h1);
        check("R8 irq off while disabled", 16'(irq), 16'h0);
        bus_wr(A_MODE, 8'h07);
        check("R8 irq on with enable", 16'(irq), 16'h1);
        bus_wr(A_FLAG, 8'h01);
        bus_rd(A_FLAG, d); check("R7 write of 1 ignored", 16'(d), 16'h1);
        clear_flag();
        check("R7 clear write", 16'(flag), 16'h0);
        check("R8 irq follows clear", 16'(irq), 16'h0);
    endtask

    task automatic t_disabled();
        bus_wr(A_MODE, 8'h05);          // compare enable, no match enable
        pulse_tb(16'h1234);
        check("R6 match enable off", 16'(flag), 16'h0);
        bus_wr(A_MODE, 8'h06);          // match enable, no compare enable
        pulse_tb(16'h1234);
        check("R6 compare enable off", 16'(flag), 16'h0);
        check("R6 irq stays off", 16'(irq), 16'h0);
    endtask

    task automatic t_half_update();
        bus_wr(A_HI, 8'h12);            // rearm on 0x1234
        bus_wr(A_LO, 8'h78);            // half updated: 0x1278
        pulse_tb(16'h1278);
        check("R10 half value no flag", 16'(flag), 16'h0);
        pulse_tb(16'h1234);
        check("R10 old value no flag", 16'(flag), 16'h0);
        bus_wr(A_HI, 8'h56);
        pulse_tb(16'h5678);
        check("R5 new value matches", 16'(flag), 16'h1);
        clear_flag();
    endtask

    task automatic t_race();
        @(negedge clk);
        tbase = 16'h5678;
        wr_en = 1'b1; addr = A_FLAG; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        tbase = IDLE;
        check("R9 match beats clear", 16'(flag), 16'h1);
        clear_flag();
        check("R9 later clear works", 16'(flag), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_match();
        t_disabled();
        t_half_update();
        t_race();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule